// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Masking

This block watches the running calendar time and raises an alarm when the current time agrees with a programmed alarm pattern. A calendar counter supplies four BCD time bytes: minute, hour, day of month and weekday. Four alarm registers hold BCD values for the same four fields. Each alarm register carries its own disable bit. A disabled field is left out of the comparison, so software can ask for alarms such as "every day at 07:15" or "every Monday". The resolution is one minute, because seconds are never compared.

When every enabled field agrees on a one-second tick, and the time did not already agree on the previous tick, a sticky alarm flag is set. Software clears the flag by writing a 0 to its bit in the control register. When the interrupt-enable bit is also set, the flag drives an active-low, level-sensitive interrupt. The register port is a simple write strobe with a combinational read mux. The surrounding bus interface and the timer interrupt belong to other blocks.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, the four alarm registers read 0x80 (field disabled), the control register reads 0x00 and `alarm_irq_n` is high.
- R2: The alarm registers sit at addresses 0x9 (minute), 0xA (hour), 0xB (day) and 0xC (weekday), and each stores and reads back all 8 bits written. The control register at 0x1 reads the flag in bit 3 and the interrupt enable in bit 1, with its other bits reading 0. Any other address reads 0x00.
- R3: Bit 7 of an alarm register disables that field. A disabled field always counts as agreeing with the time.
- R4: Only the value bits take part in the comparison: bits 6:0 for minute, 5:0 for hour and day, and 2:0 for weekday. Higher bits of both the time inputs and the alarm registers are ignored.
- R5: When all four fields are disabled, the flag is never set.
- R6: On a cycle with `tick_1hz` high, the flag is set if the time agrees and did not agree on the previous tick. The flag is readable on the following cycle.
- R7: Later ticks that still agree do not set the flag again, even after a clear. A new alarm needs the time to stop agreeing on some tick and then agree again.
- R8: Writing control with bit 3 = 0 clears the flag, and writing bit 3 = 1 leaves it unchanged. If a set event and a clear fall in the same cycle, the flag ends up set.
- R9: `alarm_irq_n` is low exactly while the flag and the interrupt enable are both 1, and it follows later changes of the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second, with the time inputs already advanced |
| now_min | input | 8 | Current minute byte (BCD in bits 6:0) |
| now_hour | input | 8 | Current hour byte (BCD in bits 5:0) |
| now_mday | input | 8 | Current day-of-month byte (BCD in bits 5:0) |
| now_wday | input | 8 | Current weekday byte (bits 2:0) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| alarm_irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The hardest case to reach is a set event and a software clear in the very same cycle, because the tick and the register write come from unrelated sources. A close second is a re-entry into an agreeing minute after a clear. The directed stimulus schedules a write to control on the exact tick cycle in which the time first agrees. It also steps the minute away and back again to re-arm the edge detection. A randomized phase draws times and alarm values from small pools so that agreements, partial masks and clears collide often. A behavioural model is compared on every clock.

// File: rtl/calalm_pkg.sv
package calalm_pkg;

   localparam int NUM_FIELDS = 4;

   // register addresses; field order minute, hour, day, weekday
   localparam int ADDR_CTRL     = 1;
   localparam int ADDR_ALM_BASE = 9;

   localparam int FLAG_BIT = 3;
   localparam int IE_BIT   = 1;

   // number of value bits of each field
   function automatic int field_width(input int idx);
      case (idx)
         0:       return 7;
         1:       return 6;
         2:       return 6;
         default: return 3;
      endcase
   endfunction

endpackage

// File: rtl/calalm_field_cmp.sv
module calalm_field_cmp #(
   parameter int REG_W   = 8,
   parameter int VAL_W   = 7,
   parameter int DIS_BIT = 7
) (
   input  logic [REG_W-1:0] alarm_i,
   input  logic [REG_W-1:0] now_i,
   output logic             en_o,
   output logic             hit_o
);

   localparam logic [REG_W-1:0] VAL_MASK = REG_W'((1 << VAL_W) - 1);

   if (VAL_W > DIS_BIT || DIS_BIT >= REG_W) begin : g_bad_width
      $error("calalm_field_cmp: value field overlaps disable bit");
   end

   assign en_o  = ~alarm_i[DIS_BIT];
   assign hit_o = ((alarm_i ^ now_i) & VAL_MASK) == '0;

endmodule

// File: rtl/calalm_regs.sv
module calalm_regs
   import calalm_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int ADDR_W  = 4,
   parameter int DIS_BIT = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [REG_W-1:0]                 wdata_i,
   input  logic                             flag_i,
   output logic [NUM_FIELDS-1:0][REG_W-1:0] alm_o,
   output logic                             ie_o,
   output logic                             clr_o,
   output logic [REG_W-1:0]                 rdata_o
);

   localparam logic [REG_W-1:0] ALM_RST = REG_W'(1) << DIS_BIT;

   if ((ADDR_ALM_BASE + NUM_FIELDS) > (1 << ADDR_W)) begin : g_bad_addr
      $error("calalm_regs: address width too small for register map");
   end

   logic ctrl_sel;
   assign ctrl_sel = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
   assign clr_o    = ctrl_sel && !wdata_i[FLAG_BIT];

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_alm
      logic sel;
      assign sel = we_i && (addr_i == ADDR_W'(ADDR_ALM_BASE + g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   alm_o[g] <= ALM_RST;
         else if (sel) alm_o[g] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ie_o <= 1'b0;
      else if (ctrl_sel) ie_o <= wdata_i[IE_BIT];
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(ADDR_CTRL)) begin
         rdata_o[FLAG_BIT] = flag_i;
         rdata_o[IE_BIT]   = ie_o;
      end
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (addr_i == ADDR_W'(ADDR_ALM_BASE + i)) rdata_o = alm_o[i];
      end
   end

endmodule

// File: rtl/calalm_flag.sv
module calalm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic match_i,
   input  logic clr_i,
   output logic flag_o
);

   logic last_q;
   logic set_ev;

   assign set_ev = tick_i && match_i && !last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_q <= 1'b0;
      else if (tick_i) last_q <= match_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_ev) flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   // R6
   flag_rise_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(tick_i && match_i && !last_q));

   // R7
   no_reset_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && match_i && last_q && !clr_i) |=> $stable(flag_o));

   // R8
   clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(tick_i && match_i && !last_q)) |=> !flag_o);

   // R8
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && tick_i && match_i && !last_q) |=> flag_o);

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
   import calalm_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int ADDR_W  = 4,
   parameter int DIS_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic [REG_W-1:0]  now_min,
   input  logic [REG_W-1:0]  now_hour,
   input  logic [REG_W-1:0]  now_mday,
   input  logic [REG_W-1:0]  now_wday,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              alarm_irq_n
);

   logic [NUM_FIELDS-1:0][REG_W-1:0] now_vec;
   logic [NUM_FIELDS-1:0][REG_W-1:0] alm_vec;
   logic [NUM_FIELDS-1:0]            en_v;
   logic [NUM_FIELDS-1:0]            hit_v;
   logic                             match;
   logic                             ie;
   logic                             clr;
   logic                             flag_q;

   assign now_vec = {now_wday, now_mday, now_hour, now_min};

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
      calalm_field_cmp #(
         .REG_W  (REG_W),
         .VAL_W  (field_width(g)),
         .DIS_BIT(DIS_BIT)
      ) u_cmp (
         .alarm_i(alm_vec[g]),
         .now_i  (now_vec[g]),
         .en_o   (en_v[g]),
         .hit_o  (hit_v[g])
      );
   end

   assign match = (|en_v) && (&(hit_v | ~en_v));

   calalm_regs #(
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W),
      .DIS_BIT(DIS_BIT)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (reg_we),
      .addr_i (reg_addr),
      .wdata_i(reg_wdata),
      .flag_i (flag_q),
      .alm_o  (alm_vec),
      .ie_o   (ie),
      .clr_o  (clr),
      .rdata_o(reg_rdata)
   );

   calalm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_1hz),
      .match_i(match),
      .clr_i  (clr),
      .flag_o (flag_q)
   );

   assign alarm_irq_n = ~(flag_q & ie);

   // R5
   no_alarm_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(|en_v));

   // R9
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie) |-> alarm_irq_n);

endmodule

// File: tb/cal_alarm_match_tb.sv
module cal_alarm_match_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] n_min = 8'h00, n_hour = 8'h00, n_mday = 8'h01, n_wday = 8'h00;
   logic       we = 1'b0;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cal_alarm_match u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick),
      .now_min(n_min), .now_hour(n_hour), .now_mday(n_mday), .now_wday(n_wday),
      .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .alarm_irq_n(irq_n)
   );

   // behavioural reference model
   logic [7:0] m_alm [4];
   bit m_flag, m_ie, m_last;
   logic [7:0] m_mask [4] = '{8'h7f, 8'h3f, 8'h3f, 8'h07};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) m_alm[i] = 8'h80;
         m_flag = 0; m_ie = 0; m_last = 0;
      end else begin
         logic [7:0] nv [4];
         bit any_en, ok, m, setev;
         nv[0] = n_min; nv[1] = n_hour; nv[2] = n_mday; nv[3] = n_wday;
         any_en = 0; ok = 1;
         for (int i = 0; i < 4; i++) begin
            if (!m_alm[i][7]) begin
               any_en = 1;
               if (((m_alm[i] ^ nv[i]) & m_mask[i]) != 8'h00) ok = 0;
            end
         end
         m = any_en && ok;
         setev = tick && m && !m_last;
         if (tick) m_last = m;
         if (we) begin
            if (addr >= 4'h9 && addr <= 4'hC) m_alm[addr - 4'h9] = wdata;
            if (addr == 4'h1) begin
               m_ie = wdata[1];
               if (!wdata[3]) m_flag = 0;
            end
         end
         if (setev) m_flag = 1;
      end
   end

   function automatic logic [7:0] model_rd(input logic [3:0] a);
      if (a == 4'h1) return {4'h0, m_flag, 1'b0, m_ie, 1'b0};
      if (a >= 4'h9 && a <= 4'hC) return m_alm[a - 4'h9];
      return 8'h00;
   endfunction

   // per-clock comparison against the model (R2, R6, R9)
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (irq_n !== !(m_flag && m_ie)) begin
            errors++;
            $display("FAIL R9 irq: actual %0b expected %0b at %0t", irq_n, !(m_flag && m_ie), $time);
         end
         checks++;
         if (rdata !== model_rd(addr)) begin
            errors++;
            $display("FAIL R2/R6 rdata @%h: actual %h expected %h at %0t", addr, rdata, model_rd(addr), $time);
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk); #2; we = 1; addr = a; wdata = d;
      @(posedge clk); #2; we = 0;
   endtask

   task automatic tk(input logic [7:0] mi, input logic [7:0] hr, input logic [7:0] dy, input logic [7:0] wd);
      @(posedge clk); #2; n_min = mi; n_hour = hr; n_mday = dy; n_wday = wd; tick = 1;
      @(posedge clk); #2; tick = 0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(posedge clk); #2; we = 0; tick = 0; addr = a;
      @(negedge clk); #1;
      chk(tag, rdata, exp);
   endtask

   task automatic irq_is(input logic exp, input string tag);
      @(negedge clk); #1;
      chk(tag, {7'h0, irq_n}, {7'h0, exp});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3); rst_n = 1'b1;
      // R1
      rd(4'h9, 8'h80, "R1 minute reset");
      rd(4'hC, 8'h80, "R1 weekday reset");
      rd(4'h1, 8'h00, "R1 ctrl reset");
      irq_is(1'b1, "R1 irq reset");
      // R2
      wr(4'h9, 8'h30); wr(4'hA, 8'h12); wr(4'h1, 8'h02);
      rd(4'hA, 8'h12, "R2 hour readback");
      rd(4'h5, 8'h00, "R2 unmapped read");
      // R6
      tk(8'h29, 8'h12, 8'h05, 8'h02);
      rd(4'h1, 8'h02, "R6 no match yet");
      tk(8'h30, 8'h12, 8'h05, 8'h02);
      rd(4'h1, 8'h0A, "R6 flag set on entry");
      irq_is(1'b0, "R9 irq asserted");
      // R8
      wr(4'h1, 8'h0A);
      rd(4'h1, 8'h0A, "R8 write one keeps flag");
      wr(4'h1, 8'h02);
      rd(4'h1, 8'h02, "R8 write zero clears");
      irq_is(1'b1, "R9 irq released");
      // R7
      tk(8'h30, 8'h12, 8'h05, 8'h02);
      rd(4'h1, 8'h02, "R7 no re-set same minute");
      tk(8'h31, 8'h12, 8'h05, 8'h02);
      tk(8'h30, 8'h12, 8'h05, 8'h02);
      rd(4'h1, 8'h0A, "R7 re-entry sets again");
      // R9
      wr(4'h1, 8'h08);
      irq_is(1'b1, "R9 enable off");
      rd(4'h1, 8'h08, "R9 flag held with enable off");
      wr(4'h1, 8'h0A);
      irq_is(1'b0, "R9 enable on again");
      wr(4'h1, 8'h02);
      // R4
      tk(8'h31, 8'h12, 8'h05, 8'h02);
      wr(4'hA, 8'h52);
      tk(8'hB0, 8'hD2, 8'h05, 8'h02);
      rd(4'h1, 8'h0A, "R4 upper bits ignored");
      rd(4'hA, 8'h52, "R2 full byte stored");
      wr(4'h1, 8'h02);
      // R5
      wr(4'h9, 8'h80); wr(4'hA, 8'h80); wr(4'hB, 8'h80); wr(4'hC, 8'h80);
      tk(8'h31, 8'h12, 8'h05, 8'h02);
      tk(8'h30, 8'h12, 8'h05, 8'h02);
      rd(4'h1, 8'h02, "R5 all disabled no flag");
      // R3
      wr(4'hC, 8'h03);
      tk(8'h17, 8'h09, 8'h21, 8'hFB);
      rd(4'h1, 8'h0A, "R3 only weekday enabled");
      wr(4'h1, 8'h02);
      // R8 set wins over same-cycle clear
      wr(4'hC, 8'h04);
      tk(8'h17, 8'h09, 8'h21, 8'h03);
      @(posedge clk); #2; n_wday = 8'h04; tick = 1; we = 1; addr = 4'h1; wdata = 8'h02;
      @(posedge clk); #2; tick = 0; we = 0;
      rd(4'h1, 8'h0A, "R8 set beats clear");
      // randomized phase, checked every clock by the model
      for (int c = 0; c < 4000; c++) begin
         @(posedge clk); #2;
         tick  = ($urandom_range(0, 3) == 0);
         n_min = ($urandom_range(0, 1) != 0) ? 8'h30 : (($urandom_range(0, 1) != 0) ? 8'hB0 : 8'h31);
         n_hour = ($urandom_range(0, 3) != 0) ? 8'h12 : 8'h13;
         n_mday = ($urandom_range(0, 1) != 0) ? 8'h05 : 8'h45;
         n_wday = 8'($urandom_range(0, 7)) | (($urandom_range(0, 1) != 0) ? 8'hF8 : 8'h00);
         we = ($urandom_range(0, 7) == 0);
         case ($urandom_range(0, 5))
            0: begin addr = 4'h9; wdata = ($urandom_range(0, 1) != 0) ? 8'h30 : 8'h80; end
            1: begin addr = 4'hA; wdata = ($urandom_range(0, 1) != 0) ? 8'h12 : 8'h92; end
            2: begin addr = 4'hB; wdata = ($urandom_range(0, 1) != 0) ? 8'h05 : 8'h80; end
            3: begin addr = 4'hC; wdata = 8'($urandom_range(0, 7)) | (($urandom_range(0, 1) != 0) ? 8'h80 : 8'h00); end
            4: begin addr = 4'h1; wdata = 8'($urandom_range(0, 15)); end
            default: begin addr = 4'h5; wdata = 8'hFF; end
         endcase
      end
      @(posedge clk); #2; tick = 0; we = 0;
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule